// File: doc/BRIEF.md
# Conversion Timing and Data-Ready Sequencer

This block sets the pace of a delta-sigma converter core from its master clock. A prescaler makes a one-clock modulator enable, and a period counter groups those enables into conversion periods. At the end of each period the block takes the 24-bit word that the decimation filter presents on `result_i` and places it in the output data register. It then drives the active-low data-ready line low. Shortly before every update the ready line is forced high, so that a host read never overlaps the register write.

A controller FSM with three states runs the sequencing. `ST_RUN` converts continuously. `ST_CAL` covers calibration periods and raises the busy flag. `ST_SLEEP` freezes both counters. The transitions are:
- `ST_RUN`→`ST_CAL` on a calibration request.
- `ST_CAL`→`ST_RUN` when the last calibration period ends.
- `ST_RUN`→`ST_SLEEP` and `ST_CAL`→`ST_SLEEP` on a sleep request, which abandons any calibration in progress.
- `ST_SLEEP`→`ST_RUN` on a wake request.

A resync request in either running state clears both counters, so that conversions line up with an external event.

In the requirements, P(s,d) = DIV_BASE·2^s · TICKS_BASE·2^d master clocks, where s is `speed_i` and d is `dr_i` (code 3 counts as 2). With the defaults of 128 and 1280 this gives 15, 7.5 and 3.75 results per second from a 2.4576 MHz clock at speed 0.

Top module: `cvt_seq_top`

## Requirements
- R1: While reset is held and right after it, `rdy_n_o` is 1, `busy_o` is 0 and `data_o` is 0.
- R2: `mod_en_o` is a one-clock pulse. Its spacing is DIV_BASE master clocks when `speed_i`=0 and 2·DIV_BASE when `speed_i`=1.
- R3: `rdy_n_o` falls at the end of each conversion period, and successive falls are P(s,d) clocks apart. A `dr_i` of 3 gives the same period as a `dr_i` of 2.
- R4: Before each register update, `rdy_n_o` rises exactly PRE_CLKS master clocks ahead of the edge where it falls again.
- R5: When `rdy_n_o` falls after a normal conversion, `data_o` equals the `result_i` value present in the final cycle of that period. `data_o` changes only together with a low ready line.
- R6: A one-clock `rd_done_i` pulse sets `rdy_n_o` high on the next edge and leaves `data_o` unchanged.
- R7: A `cal_req_i` pulse uses the encoding 01 = offset, 10 = gain, 11 = both, 00 = none. It restarts the counters and raises `busy_o` on the next edge. Offset-only or gain-only calibration lasts 2 periods and the combined calibration lasts 4. At the end `busy_o` drops and `rdy_n_o` falls.
- R8: The first conversion after a calibration is discarded: `rdy_n_o` stays high and `data_o` keeps its value. The second conversion updates both.
- R9: A `resync_i` pulse clears the counters, and the next fall of `rdy_n_o` comes exactly P clocks after the edge that sampled the pulse.
- R10: In sleep, `mod_en_o` stays 0 and no conversion completes. A `wake_i` pulse restarts the counters from zero, and the first fall comes P clocks after the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_i | input | 1 | Prescaler select: 0 divides by DIV_BASE, 1 by twice that |
| dr_i | input | 2 | Data-rate code, period scale 2^dr (3 acts as 2) |
| resync_i | input | 1 | Pulse: restart the conversion period |
| sleep_i | input | 1 | Pulse: enter sleep |
| wake_i | input | 1 | Pulse: leave sleep |
| cal_req_i | input | 2 | Calibration start pulse, kind encoded as in R7 |
| rd_done_i | input | 1 | Pulse: host finished reading the data register |
| result_i | input | 24 | Filter result word |
| mod_en_o | output | 1 | Modulator clock enable |
| conv_done_o | output | 1 | High in the final cycle of each period |
| rdy_n_o | output | 1 | Active-low data ready |
| busy_o | output | 1 | Calibration in progress |
| data_o | output | 24 | Output data register |

## Verification
The bench measures the spacing of ready falls for every speed and rate code, code 3 included. A divider that picked the wrong shift, or a rate decoder that let code 3 through as 8×, shows up there as the wrong interval. It times each fall from the edge of a resync, wake or calibration request. Off-by-one counter clears, or a wake that resumes a half-finished period, move that fall by a few clocks and fail. After each calibration the bench looks at the ready line and the data word in the window of the discarded result. A design that forgets the discard, or counts 2 periods for the combined calibration, either publishes stale filter data or finishes early.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CAL   = 2'd1,
        ST_SLEEP = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        CAL_NONE   = 2'b00,
        CAL_OFFSET = 2'b01,
        CAL_GAIN   = 2'b10,
        CAL_BOTH   = 2'b11
    } cal_kind_t;

    // number of conversion periods a calibration occupies
    function automatic logic [2:0] cal_periods(cal_kind_t kind);
        return (kind == CAL_BOTH) ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/cvt_prescaler.sv
// Divides the master clock into the modulator enable. PRE_CLKS must be
// smaller than DIV_BASE so the warning falls inside the last tick.
module cvt_prescaler #(
    parameter int DIV_BASE = 128,
    parameter int PRE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic speed_i,
    output logic tick_o,
    output logic warn_phase_o
);
    localparam int PW = $clog2(2 * DIV_BASE) + 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim = speed_i ? PW'(2 * DIV_BASE - 1) : PW'(DIV_BASE - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i || restart_i) begin
            phase_q <= '0;
        end else if (phase_q >= lim) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign tick_o       = run_i && (phase_q >= lim);
    assign warn_phase_o = run_i && (phase_q == lim - PW'(PRE_CLKS));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("modulator enable wider than one clock");

endmodule

// File: rtl/cvt_period_ctr.sv
// Counts modulator ticks within one conversion period.
module cvt_period_ctr #(
    parameter int TICKS_BASE = 1280
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] dr_i,
    input  logic       tick_i,
    input  logic       warn_phase_i,
    output logic       done_o,
    output logic       warn_o
);
    localparam int CW = $clog2(4 * TICKS_BASE) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          last_tick;

    // rate code 3 maps onto the same period as code 2
    always_comb begin
        unique case (dr_i)
            2'd0:    lim = CW'(TICKS_BASE - 1);
            2'd1:    lim = CW'(2 * TICKS_BASE - 1);
            default: lim = CW'(4 * TICKS_BASE - 1);
        endcase
    end

    assign last_tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= last_tick ? '0 : cnt_q + CW'(1);
        end
    end

    assign done_o = tick_i && last_tick;
    assign warn_o = warn_phase_i && last_tick;

    // R4
    warn_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> !done_o)
        else $error("ready warning coincides with update");

endmodule

// File: rtl/cvt_seq_top.sv
module cvt_seq_top
    import cvt_seq_pkg::*;
#(
    parameter int DIV_BASE   = 128,
    parameter int TICKS_BASE = 1280,
    parameter int PRE_CLKS   = 4,
    parameter int DATA_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_i,
    input  logic [1:0]        dr_i,
    input  logic              resync_i,
    input  logic              sleep_i,
    input  logic              wake_i,
    input  logic [1:0]        cal_req_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              mod_en_o,
    output logic              conv_done_o,
    output logic              rdy_n_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o
);
    seq_state_t        state_q, state_d;
    logic [2:0]        cal_left_q;
    logic              discard_q;
    logic              rdy_n_q;
    logic [DATA_W-1:0] data_q;

    logic run, restart, start_cal;
    logic mod_tick, warn_phase, period_done, period_warn;
    cal_kind_t cal_kind;

    assign cal_kind  = cal_kind_t'(cal_req_i);
    assign run       = (state_q != ST_SLEEP);
    assign start_cal = (state_q == ST_RUN) && !sleep_i && (cal_kind != CAL_NONE);
    assign restart   = run && !sleep_i && (resync_i || start_cal);

    cvt_prescaler #(
        .DIV_BASE (DIV_BASE),
        .PRE_CLKS (PRE_CLKS)
    ) presc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .restart_i    (restart),
        .speed_i      (speed_i),
        .tick_o       (mod_tick),
        .warn_phase_o (warn_phase)
    );

    cvt_period_ctr #(
        .TICKS_BASE (TICKS_BASE)
    ) period_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .restart_i    (restart),
        .dr_i         (dr_i),
        .tick_i       (mod_tick),
        .warn_phase_i (warn_phase),
        .done_o       (period_done),
        .warn_o       (period_warn)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_i)        state_d = ST_SLEEP;
                else if (start_cal) state_d = ST_CAL;
            end
            ST_CAL: begin
                if (sleep_i)                                 state_d = ST_SLEEP;
                else if (period_done && cal_left_q == 3'd1) state_d = ST_RUN;
            end
            ST_SLEEP: begin
                if (wake_i) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs: ready line, data register, calibration bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n_q    <= 1'b1;
            data_q     <= '0;
            cal_left_q <= '0;
            discard_q  <= 1'b0;
        end else if (start_cal) begin
            cal_left_q <= cal_periods(cal_kind);
            rdy_n_q    <= 1'b1;
            discard_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CAL: begin
                    if (!sleep_i && period_done) begin
                        if (cal_left_q == 3'd1) begin
                            rdy_n_q   <= 1'b0;
                            discard_q <= 1'b1;
                        end
                        cal_left_q <= cal_left_q - 3'd1;
                    end else if (period_warn) begin
                        rdy_n_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (period_done) begin
                        if (discard_q) begin
                            discard_q <= 1'b0;
                        end else begin
                            data_q  <= result_i;
                            rdy_n_q <= 1'b0;
                        end
                    end else if (period_warn || rd_done_i) begin
                        rdy_n_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mod_en_o    = mod_tick;
    assign conv_done_o = period_done;
    assign rdy_n_o     = rdy_n_q;
    assign busy_o      = (state_q == ST_CAL);
    assign data_o      = data_q;

    // R3
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n_q) |-> $past(period_done))
        else $error("ready fell without a period end");

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> !rdy_n_q)
        else $error("data changed while ready high");

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!mod_tick && !period_done))
        else $error("activity during sleep");

    // R7
    cal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(sleep_i)) |-> !rdy_n_q)
        else $error("calibration ended without ready");

endmodule

// File: tb/cvt_seq_top_tb_top.sv
`timescale 1ns/1ps
module cvt_seq_top_tb_top;
    localparam int DIVB  = 8;
    localparam int TICKB = 5;
    localparam int PRE   = 3;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        speed, resync, sleep_r, wake, rd_done;
    logic [1:0]  dr, cal_req;
    logic [23:0] result;
    logic        mod_en, conv_done, rdy_n, busy;
    logic [23:0] data;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int rise_cyc;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cvt_seq_top #(
        .DIV_BASE   (DIVB),
        .TICKS_BASE (TICKB),
        .PRE_CLKS   (PRE),
        .DATA_W     (24)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_i     (speed),
        .dr_i        (dr),
        .resync_i    (resync),
        .sleep_i     (sleep_r),
        .wake_i      (wake),
        .cal_req_i   (cal_req),
        .rd_done_i   (rd_done),
        .result_i    (result),
        .mod_en_o    (mod_en),
        .conv_done_o (conv_done),
        .rdy_n_o     (rdy_n),
        .busy_o      (busy),
        .data_o      (data)
    );

    function automatic int period(int s, int d);
        int de;
        de = (d == 3) ? 2 : d;
        return DIVB * (1 << s) * TICKB * (1 << de);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fall(output int fcyc);
        logic prev;
        prev = rdy_n;
        rise_cyc = -1;
        fcyc = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rdy_n && !prev) rise_cyc = cyc;
            if (!rdy_n && prev) begin
                fcyc = cyc;
                return;
            end
            prev = rdy_n;
        end
    endtask

    task automatic pulse_resync(output int c0);
        @(negedge clk);
        c0 = cyc;
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    task automatic t_reset();
        int c0, f;
        rst_n = 1'b0; speed = 0; dr = 0; resync = 0; sleep_r = 0; wake = 0;
        cal_req = 0; rd_done = 0; result = 24'hA5A5A5;
        repeat (4) @(negedge clk);
        chk(rdy_n == 1'b1, "R1", "rdy_n in reset", rdy_n, 1);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(data == 24'h0, "R1", "data in reset", data, 0);
        c0 = cyc;
        rst_n = 1'b1;
        wait_fall(f);
        chk(f - c0 == period(0, 0), "R3", "first period after reset", f - c0, period(0, 0));
        chk(data == 24'hA5A5A5, "R5", "first data", data, 24'hA5A5A5);
    endtask

    task automatic t_tick_rate(input int s);
        int a, b, c0;
        speed = s[0];
        pulse_resync(c0);
        a = -1; b = -1;
        for (int i = 0; i < 100 && b < 0; i++) begin
            @(negedge clk);
            if (mod_en) begin
                if (a < 0) a = cyc; else b = cyc;
            end
        end
        chk(b - a == DIVB * (1 << s), "R2", "tick spacing", b - a, DIVB * (1 << s));
        @(negedge clk);
        chk(mod_en == 1'b0, "R2", "tick width", mod_en, 0);
    endtask

    task automatic t_period(input int s, input int d);
        int c0, f1, f2;
        logic [23:0] pat;
        speed = s[0]; dr = d[1:0];
        pat = 24'h123400 + 24'(s * 16 + d);
        result = pat;
        pulse_resync(c0);
        wait_fall(f1);
        chk(f1 - (c0 + 1) == period(s, d), "R9", "resync to fall", f1 - (c0 + 1), period(s, d));
        chk(data == pat, "R5", "data pattern", data, pat);
        wait_fall(f2);
        chk(f2 - f1 == period(s, d), "R3", "fall spacing", f2 - f1, period(s, d));
        chk(f2 - rise_cyc == PRE, "R4", "ready lead", f2 - rise_cyc, PRE);
    endtask

    task automatic t_read_done();
        int f;
        logic [23:0] held;
        speed = 0; dr = 0;
        wait_fall(f);
        held = data;
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk(rdy_n == 1'b1, "R6", "ready after read", rdy_n, 1);
        chk(data == held, "R6", "data held after read", data, held);
    endtask

    task automatic t_resync_mid();
        int f, c0;
        speed = 0; dr = 1;
        wait_fall(f);
        repeat (13) @(negedge clk);
        pulse_resync(c0);
        wait_fall(f);
        chk(f - (c0 + 1) == period(0, 1), "R9", "mid-period resync", f - (c0 + 1), period(0, 1));
    endtask

    task automatic t_calib(input logic [1:0] kind);
        int c0, f, k, p, w;
        logic [23:0] old_d, new_d;
        speed = 0; dr = 0;
        p = period(0, 0);
        k = (kind == 2'b11) ? 4 : 2;
        wait_fall(f);
        old_d = data;
        @(negedge clk);
        c0 = cyc;
        cal_req = kind;
        @(negedge clk);
        cal_req = 2'b00;
        chk(busy == 1'b1, "R7", "busy at start", busy, 1);
        new_d = 24'h5A0000 + 24'(kind);
        result = new_d;
        wait_fall(f);
        chk(f - (c0 + 1) == k * p, "R7", "calibration length", f - (c0 + 1), k * p);
        chk(busy == 1'b0, "R7", "busy at end", busy, 0);
        w = c0 + 1 + (k + 1) * p;
        while (cyc < w) @(negedge clk);
        chk(rdy_n == 1'b1, "R8", "first result suppressed", rdy_n, 1);
        chk(data == old_d, "R8", "data not updated", data, old_d);
        wait_fall(f);
        chk(f - (c0 + 1) == (k + 2) * p, "R8", "second result time", f - (c0 + 1), (k + 2) * p);
        chk(data == new_d, "R8", "second result data", data, new_d);
    endtask

    task automatic t_sleep_wake();
        int c0, f, bad;
        logic r0;
        speed = 0; dr = 0;
        @(negedge clk);
        sleep_r = 1'b1;
        @(negedge clk);
        sleep_r = 1'b0;
        r0 = rdy_n;
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (mod_en || conv_done || rdy_n != r0) bad++;
        end
        chk(bad == 0, "R10", "quiet cycles in sleep", bad, 0);
        c0 = cyc;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        wait_fall(f);
        chk(f - (c0 + 1) == period(0, 0), "R10", "wake to fall", f - (c0 + 1), period(0, 0));
    endtask

    initial begin
        t_reset();
        t_tick_rate(0);
        t_tick_rate(1);
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 4; d++)
                t_period(s, d);
        t_read_done();
        t_resync_mid();
        t_calib(2'b01);
        t_calib(2'b10);
        t_calib(2'b11);
        t_sleep_wake();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule